// File: doc/BRIEF.md
# Flash Memory-Operation Control Registers

This block is the register front end of a serial NOR flash controller. Software reaches it through 32-bit single-beat reads and writes on a valid/ready bus, with seven word registers. One register takes commands: an opcode in bits [7:0] and a target sector index starting at bit 8. Three commands are understood: bulk erase, sector erase and sector protect. The block keeps one protect bit per 64 KiB sector. Erase commands and data-window writes are checked against those bits before they are passed on to the flash engine.

A rejected operation does not reach the engine. Instead it sets a sticky flag in an interrupt status register, with one flag for erase and one for write. Software clears a flag by writing a one to it. The flags are gated by a mask register and then combined into one interrupt line. The erase duration is modelled by a busy counter, which shows as bit 0 of the status register. The serial signalling, the quad-lane engine and the array itself live outside this block.

Top module: `flash_opctl`

## Requirements
- R1: After reset, the status, memory-operation, interrupt-status, interrupt-mask and chip-select registers read 0 and irq is low. All protect bits are clear. Register word addresses: 0 status, 1 silicon ID, 2 read-ID, 3 memory operation, 4 interrupt status, 5 interrupt mask, 6 chip select.
- R2: The silicon-ID register reads the SID_VAL parameter and the read-ID register reads ADDR_W+6, so the capacity 2^(readID-6) equals the data-window size. Writes to either register leave the values unchanged. A read returns its data with regRvalid in the cycle after it is accepted.
- R3: An idle write of opcode 2 (sector erase) to an unprotected sector pulses eraseStart for one cycle after the write, with eraseBulk low and eraseSector equal to bits [8 +: IDX_W]. Status bit 0 then reads 1 for exactly BUSY_CYCLES cycles.
- R4: Opcode 3 (protect) sets the protect bit of the indexed sector and starts no erase. A later sector erase of that sector starts nothing and sets interrupt-status bit 0 (illegal erase).
- R5: Opcode 1 (bulk erase) pulses eraseStart with eraseBulk high when no sector is protected. When any sector is protected it starts nothing and sets interrupt-status bit 0.
- R6: A memory-operation write while busy is ignored entirely: no erase, no protection change, no flag, and the memory-operation readback keeps the last accepted word.
- R7: A data-window write whose sector (winAddr bits [ADDR_W-1:16]) is protected is not forwarded and sets interrupt-status bit 1 (illegal write). Other window writes appear on memWrEn/memWrAddr/memWrData one cycle later.
- R8: Writing 1 to an interrupt-status bit clears it and writing 0 leaves it. A flag raised in the same cycle as its clear stays set.
- R9: irq is high exactly when some interrupt-status bit and the same interrupt-mask bit (bits [1:0]) are both 1. The flags set and clear regardless of the mask.
- R10: A memory-operation word whose opcode is not 1, 2 or 3 starts nothing and changes no flag or protect bit.
- R11: The chip-select register stores and reads back bits [CS_W-1:0] of the written word, and chipSel drives that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regValid | input | 1 | Register access request |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 3 | Register word address |
| regWdata | input | 32 | Register write data |
| regReady | output | 1 | Register access accepted (always 1) |
| regRvalid | output | 1 | Read data valid, one cycle after the read |
| regRdata | output | 32 | Read data |
| winValid | input | 1 | Data-window write request |
| winAddr | input | ADDR_W | Data-window byte address |
| winData | input | 32 | Data-window write data |
| winReady | output | 1 | Window write accepted (always 1) |
| memWrEn | output | 1 | Forwarded write to the flash engine |
| memWrAddr | output | ADDR_W | Forwarded write address |
| memWrData | output | 32 | Forwarded write data |
| eraseStart | output | 1 | One-cycle erase launch to the engine |
| eraseBulk | output | 1 | Launch is a whole-device erase |
| eraseSector | output | IDX_W | Sector of a sector erase |
| chipSel | output | CS_W | Chip-select register value |
| irq | output | 1 | Masked interrupt |

## Verification
The bench first issues sector erases to unprotected sectors and bulk erases with protection clear, then issues the same commands against a protected sector. This shows that the protect lookup uses the commanded index and not some fixed sector. Commands written during busy and commands with unknown opcodes are used to show that nothing is launched and that the readback alone reflects what was accepted. Window writes alternate between protected and unprotected sectors, so forwarding and the write flag are each seen in both states. A flag clear placed in the same cycle as a new violation shows the set-over-clear ordering. Changing the mask while flags stand shows that the interrupt line follows the mask and that the flags do not.

// File: rtl/flash_opctl_pkg.sv
package flash_opctl_pkg;

  typedef enum logic [2:0] {
    REG_STAT  = 3'd0,
    REG_SID   = 3'd1,
    REG_RDID  = 3'd2,
    REG_MEMOP = 3'd3,
    REG_ISR   = 3'd4,
    REG_IMR   = 3'd5,
    REG_CSEL  = 3'd6
  } regSel_e;

  localparam logic [7:0] OP_BULK = 8'd1;
  localparam logic [7:0] OP_SECT = 8'd2;
  localparam logic [7:0] OP_PROT = 8'd3;

  typedef struct packed {
    logic opWr;      // memory-operation word accepted
    logic protSet;   // set protect bit of sectIdx
    logic eraseGo;   // launch an erase
    logic bulk;      // launch is bulk
    logic illErase;  // rejected erase
    logic illWrite;  // rejected window write
    logic fwdWr;     // forward window write
    logic isrWr;     // write-one-to-clear on status flags
    logic imrWr;     // mask register write
    logic csWr;      // chip-select register write
  } strobe_t;

endpackage

// File: rtl/flash_opctl_ctrl.sv
module flash_opctl_ctrl
  import flash_opctl_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int SECT_BITS   = 16,
  parameter int BUSY_CYCLES = 40,
  localparam int IDX_W      = ADDR_W - SECT_BITS,
  localparam int NSECT      = 1 << IDX_W,
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             regValid,
  input  logic             regWrite,
  input  logic [2:0]       regAddr,
  input  logic [8+IDX_W-1:0] cmdWord,
  input  logic             winValid,
  input  logic [IDX_W-1:0] winSect,
  input  logic [NSECT-1:0] protBits,
  output strobe_t          strb,
  output logic [IDX_W-1:0] sectIdx,
  output logic             busy
);

  logic [CNT_W-1:0] busyCnt;
  logic             wrAcc;
  logic [7:0]       opCode;

  assign wrAcc   = regValid && regWrite;
  assign opCode  = cmdWord[7:0];
  assign sectIdx = cmdWord[8 +: IDX_W];
  assign busy    = (busyCnt != '0);

  always_comb begin
    strb       = '0;
    strb.isrWr = wrAcc && (regAddr == REG_ISR);
    strb.imrWr = wrAcc && (regAddr == REG_IMR);
    strb.csWr  = wrAcc && (regAddr == REG_CSEL);
    if (wrAcc && (regAddr == REG_MEMOP) && !busy) begin
      strb.opWr = 1'b1;
      case (opCode)
        OP_BULK: begin
          if (|protBits) strb.illErase = 1'b1;
          else begin
            strb.eraseGo = 1'b1;
            strb.bulk    = 1'b1;
          end
        end
        OP_SECT: begin
          if (protBits[sectIdx]) strb.illErase = 1'b1;
          else strb.eraseGo = 1'b1;
        end
        OP_PROT: strb.protSet = 1'b1;
        default: ;
      endcase
    end
    if (winValid) begin
      if (protBits[winSect]) strb.illWrite = 1'b1;
      else strb.fwdWr = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) busyCnt <= '0;
    else if (strb.eraseGo) busyCnt <= CNT_W'(BUSY_CYCLES);
    else if (busy) busyCnt <= busyCnt - CNT_W'(1);
  end

  // R3: an accepted erase keeps the block busy on the next cycle
  a_r3_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    strb.eraseGo |=> busy);

  // R6: a busy block never accepts a command word
  a_r6_busy_blocks_op: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !strb.opWr);

endmodule

// File: rtl/flash_opctl_dp.sv
module flash_opctl_dp
  import flash_opctl_pkg::*;
#(
  parameter int          ADDR_W    = 20,
  parameter int          SECT_BITS = 16,
  parameter int          CS_W      = 2,
  parameter logic [31:0] SID_VAL   = 32'h5A5A_0001,
  localparam int         IDX_W     = ADDR_W - SECT_BITS,
  localparam int         NSECT     = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [IDX_W-1:0]  sectIdx,
  input  logic              busy,
  input  logic              regRead,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  input  logic              winValid,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [31:0]       winData,
  output logic [NSECT-1:0]  protBits,
  output logic              regRvalid,
  output logic [31:0]       regRdata,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              eraseStart,
  output logic              eraseBulk,
  output logic [IDX_W-1:0]  eraseSector,
  output logic [CS_W-1:0]   chipSel,
  output logic              irq
);

  localparam logic [31:0] RDID_VAL = 32'(ADDR_W + 6);

  logic [1:0]  isrQ, imrQ, isrClr;
  logic [31:0] opQ, rdNext;

  generate
    for (genvar s = 0; s < NSECT; s++) begin : g_prot
      always_ff @(posedge clk) begin
        if (!rst_n) protBits[s] <= 1'b0;
        else if (strb.protSet && (sectIdx == IDX_W'(s))) protBits[s] <= 1'b1;
      end
    end
  endgenerate

  assign isrClr = strb.isrWr ? regWdata[1:0] : 2'b00;
  assign irq    = |(isrQ & imrQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isrQ    <= '0;
      imrQ    <= '0;
      chipSel <= '0;
      opQ     <= '0;
    end else begin
      isrQ <= (isrQ & ~isrClr) | {strb.illWrite, strb.illErase};
      if (strb.imrWr) imrQ <= regWdata[1:0];
      if (strb.csWr) chipSel <= regWdata[CS_W-1:0];
      if (strb.opWr) opQ <= regWdata;
    end
  end

  always_comb begin
    case (regAddr)
      REG_STAT:  rdNext = {31'd0, busy};
      REG_SID:   rdNext = SID_VAL;
      REG_RDID:  rdNext = RDID_VAL;
      REG_MEMOP: rdNext = opQ;
      REG_ISR:   rdNext = {30'd0, isrQ};
      REG_IMR:   rdNext = {30'd0, imrQ};
      REG_CSEL:  rdNext = 32'(chipSel);
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regRvalid   <= 1'b0;
      regRdata    <= '0;
      memWrEn     <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
      eraseStart  <= 1'b0;
      eraseBulk   <= 1'b0;
      eraseSector <= '0;
    end else begin
      regRvalid  <= regRead;
      if (regRead) regRdata <= rdNext;
      memWrEn    <= strb.fwdWr;
      if (strb.fwdWr) begin
        memWrAddr <= winAddr;
        memWrData <= winData;
      end
      eraseStart <= strb.eraseGo;
      if (strb.eraseGo) begin
        eraseBulk   <= strb.bulk;
        eraseSector <= sectIdx;
      end
    end
  end

  // R4: a sector erase is only launched on an unprotected sector
  a_r4_sector_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eraseGo && !strb.bulk) |-> !protBits[sectIdx]);

  // R5: a bulk erase is only launched with no protection set
  a_r5_bulk_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.eraseGo && strb.bulk) |-> (protBits == '0));

  // R8: a raised write flag is visible next cycle even under a clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    strb.illWrite |=> isrQ[1]);

  // R7: forwarded writes only follow an accepted window write
  a_r7_fwd_from_window: assert property (@(posedge clk) disable iff (!rst_n)
    memWrEn |-> $past(winValid));

endmodule

// File: rtl/flash_opctl.sv
module flash_opctl
  import flash_opctl_pkg::*;
#(
  parameter int          ADDR_W      = 20,
  parameter int          SECT_BITS   = 16,
  parameter int          BUSY_CYCLES = 40,
  parameter int          CS_W        = 2,
  parameter logic [31:0] SID_VAL     = 32'h5A5A_0001,
  localparam int         IDX_W       = ADDR_W - SECT_BITS,
  localparam int         NSECT       = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic              regReady,
  output logic              regRvalid,
  output logic [31:0]       regRdata,
  input  logic              winValid,
  input  logic [ADDR_W-1:0] winAddr,
  input  logic [31:0]       winData,
  output logic              winReady,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic              eraseStart,
  output logic              eraseBulk,
  output logic [IDX_W-1:0]  eraseSector,
  output logic [CS_W-1:0]   chipSel,
  output logic              irq
);

  strobe_t          strb;
  logic [IDX_W-1:0] sectIdx;
  logic [NSECT-1:0] protBits;
  logic             busy;

  assign regReady = 1'b1;
  assign winReady = 1'b1;

  flash_opctl_ctrl #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .cmdWord(regWdata[8+IDX_W-1:0]),
    .winValid(winValid), .winSect(winAddr[ADDR_W-1:SECT_BITS]),
    .protBits(protBits), .strb(strb), .sectIdx(sectIdx), .busy(busy)
  );

  flash_opctl_dp #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .CS_W(CS_W), .SID_VAL(SID_VAL)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .sectIdx(sectIdx), .busy(busy),
    .regRead(regValid && !regWrite), .regAddr(regAddr), .regWdata(regWdata),
    .winValid(winValid), .winAddr(winAddr), .winData(winData),
    .protBits(protBits), .regRvalid(regRvalid), .regRdata(regRdata),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .eraseStart(eraseStart), .eraseBulk(eraseBulk), .eraseSector(eraseSector),
    .chipSel(chipSel), .irq(irq)
  );

endmodule

// File: tb/tb_flash_opctl.sv
`timescale 1ns/1ps
module tb_flash_opctl;

  localparam int ADDR_W = 20;
  localparam int BUSYC  = 40;
  localparam logic [31:0] SIDV = 32'h5A5A_0001;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        regValid = 0, regWrite = 0, winValid = 0;
  logic [2:0]  regAddr = 0;
  logic [31:0] regWdata = 0, winData = 0;
  logic [ADDR_W-1:0] winAddr = 0;
  logic        regReady, regRvalid, winReady, memWrEn, eraseStart, eraseBulk, irq;
  logic [31:0] regRdata, memWrData;
  logic [ADDR_W-1:0] memWrAddr;
  logic [3:0]  eraseSector;
  logic [1:0]  chipSel;

  flash_opctl dut (.*);

  always #10 clk = ~clk;

  int    nChk = 0, nFail = 0;
  bit    done = 0;
  string curReq = "R1";

  // behavioural reference model
  bit prot[16];
  int mIsr, mImr, mCs, mOp, busyCnt;
  bit startP, bulkP, wrP, rvP;
  int sectP, wrA, wrD, rdExp;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int clr, setE, setW, idx, op;
    bit oldBusy, anyP;
    if (!rst_n) begin
      foreach (prot[i]) prot[i] = 0;
      mIsr = 0; mImr = 0; mCs = 0; mOp = 0; busyCnt = 0;
      startP = 0; wrP = 0; rvP = 0;
    end else begin
      oldBusy = (busyCnt != 0);
      startP = 0; wrP = 0; rvP = 0; clr = 0; setE = 0; setW = 0;
      if (regValid && !regWrite) begin
        rvP = 1;
        case (regAddr)
          0: rdExp = oldBusy;
          1: rdExp = SIDV;
          2: rdExp = ADDR_W + 6;
          3: rdExp = mOp;
          4: rdExp = mIsr;
          5: rdExp = mImr;
          6: rdExp = mCs;
          default: rdExp = 0;
        endcase
      end
      if (regValid && regWrite) begin
        case (regAddr)
          3: if (!oldBusy) begin
               mOp = regWdata; op = regWdata & 'hff; idx = (regWdata >> 8) & 15;
               anyP = 0; foreach (prot[i]) if (prot[i]) anyP = 1;
               if (op == 1) begin
                 if (anyP) setE = 1; else begin startP = 1; bulkP = 1; end
               end else if (op == 2) begin
                 if (prot[idx]) setE = 1; else begin startP = 1; bulkP = 0; sectP = idx; end
               end else if (op == 3) prot[idx] = 1;
             end
          4: clr = regWdata & 3;
          5: mImr = regWdata & 3;
          6: mCs = regWdata & 3;
          default: ;
        endcase
      end
      if (winValid) begin
        if (prot[winAddr >> 16]) setW = 1;
        else begin wrP = 1; wrA = winAddr; wrD = winData; end
      end
      mIsr = (mIsr & ~clr) | setE | (setW << 1);
      if (startP) busyCnt = BUSYC; else if (busyCnt > 0) busyCnt--;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    chk(irq == ((mIsr & mImr) != 0), "R9 irq", irq, (mIsr & mImr) != 0);
    chk(eraseStart == startP, {curReq, " eraseStart"}, eraseStart, startP);
    if (startP) begin
      chk(eraseBulk == bulkP, {curReq, " eraseBulk"}, eraseBulk, bulkP);
      if (!bulkP) chk(eraseSector == sectP, "R3 eraseSector", eraseSector, sectP);
    end
    chk(memWrEn == wrP, "R7 memWrEn", memWrEn, wrP);
    if (wrP) begin
      chk(memWrAddr == wrA, "R7 memWrAddr", memWrAddr, wrA);
      chk(memWrData == wrD, "R7 memWrData", memWrData, wrD);
    end
    chk(regRvalid == rvP, {curReq, " rvalid"}, regRvalid, rvP);
    if (rvP) chk(regRdata == rdExp, {curReq, " rdata"}, regRdata, rdExp);
    chk(chipSel == mCs, "R11 chipSel", chipSel, mCs);
  end

  task automatic cyc(bit rv, bit rw, int ra, int rd, bit wv, int wa, int wd);
    regValid = rv; regWrite = rw; regAddr = ra[2:0]; regWdata = rd;
    winValid = wv; winAddr = wa[ADDR_W-1:0]; winData = wd;
    @(negedge clk);
    regValid = 0; winValid = 0;
  endtask
  task automatic wr(int a, int d); cyc(1, 1, a, d, 0, 0, 0); endtask
  task automatic rd(int a); cyc(1, 0, a, 0, 0, 0, 0); endtask
  task automatic win(int a, int d); cyc(0, 0, 0, 0, 1, a, d); endtask
  task automatic idle(int n); repeat (n) @(negedge clk); endtask

  initial begin
    #(20ns * 200000);
    if (!done) begin
      done = 1; nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values of every register
    curReq = "R1";
    for (int a = 0; a < 7; a++) rd(a);
    chk(irq == 0, "R1 irq", irq, 0);
    // R2: ID registers fixed, writes ignored
    curReq = "R2";
    wr(1, 32'hFFFF_FFFF); wr(2, 32'h0000_0033); rd(1); rd(2);
    // R11: chip select store and readback
    curReq = "R11";
    wr(6, 32'hFFFF_FFF3); rd(6); wr(6, 1); rd(6);
    // R3: sector erase on sector 2, busy visible then clears
    curReq = "R3";
    wr(3, (2 << 8) | 2); rd(0); rd(3);
    // R6: protect of sector 5 during busy is ignored
    curReq = "R6";
    wr(3, (5 << 8) | 3); rd(3); rd(4);
    curReq = "R3";
    idle(BUSYC); rd(0);
    // R6: sector 5 still unprotected, so its erase launches
    curReq = "R6";
    wr(3, (5 << 8) | 2); idle(BUSYC + 2);
    // R5: bulk erase with nothing protected
    curReq = "R5";
    wr(3, 1); idle(BUSYC + 2);
    // R10: unknown opcodes do nothing
    curReq = "R10";
    wr(3, (4 << 8) | 0); wr(3, (4 << 8) | 7); rd(0); rd(4); rd(3);
    // R4: protect sector 5, then erase it
    curReq = "R4";
    wr(3, (5 << 8) | 3); rd(0); wr(3, (5 << 8) | 2); rd(4);
    // R8: clear erase flag
    curReq = "R8";
    wr(4, 1); rd(4);
    // R5: bulk erase rejected under protection
    curReq = "R5";
    wr(3, 1); rd(4); rd(0); wr(4, 3);
    // R7: protected and unprotected window writes
    curReq = "R7";
    win(32'h5_1234, 32'hDEAD_BEEF); rd(4);
    win(32'h6_0010, 32'h1234_5678); win(32'h4_FFFC, 32'hCAFE_F00D);
    // R8: clear of bit 1 in the same cycle as a new illegal write
    curReq = "R8";
    cyc(1, 1, 4, 2, 1, 32'h5_0000, 32'h1); rd(4);
    wr(4, 0); rd(4); wr(4, 2); rd(4);
    // R9: mask gating, flags independent of mask
    curReq = "R9";
    wr(5, 0); win(32'h5_0004, 0); rd(4);
    chk(irq == 0, "R9 masked irq", irq, 0);
    wr(5, 1); chk(irq == 0, "R9 other bit masked", irq, 0);
    wr(5, 2); chk(irq == 1, "R9 unmasked irq", irq, 1);
    wr(4, 2); chk(irq == 0, "R9 irq after clear", irq, 0);
    wr(3, (5 << 8) | 2); wr(5, 3); chk(irq == 1, "R9 erase flag irq", irq, 1);
    rd(5); wr(4, 1); idle(2);
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule